// File: doc/BRIEF.md
# AXI4 Write Burst Packet Buffer

This block sits on the write path of an AXI4 link, between an upstream manager (the slave-side port, prefix `s_`) and a downstream subordinate (the master-side port, prefix `m_`). Write data beats are stored in a deep data queue, and write address commands are stored in a shallow command queue. A command is only offered downstream once every beat of its burst, up to the beat marked last, has been taken in. A slow or bursty data source therefore cannot leave a downstream target holding an address while it waits for data in the middle of a burst.

Data beats are not held back. They leave on the master-side W channel as soon as they are stored, even before their command is issued, which AXI4 allows. A tally of completed but not yet issued bursts decides when the head command may go out. The write response channel is wired straight through. Everything runs on one clock with a synchronous active-low reset. AXI4-Lite traffic is not handled.

Top module: `pkt_wr_buffer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `m_awvalid` and `m_wvalid` are low, and `s_awready` and `s_wready` are high. Both queues are empty and the burst tally is zero.
- R2: Data beats leave on `m_w*` in the order they were accepted, with data, strobe and last flag unchanged. A beat accepted in cycle t is offered from cycle t+1, whether or not its command has been issued.
- R3: Commands leave on `m_aw*` in the order they were accepted, with id, address, length, size and burst type unchanged.
- R4: `m_awvalid` is high only while at least one command is queued and the number of accepted beats with `s_wlast`=1 exceeds the number of issued commands. It rises in the cycle after the WLAST handshake that completes the head command's burst, or the cycle after the command is accepted, whichever is later.
- R5: When a WLAST beat is accepted in the same cycle as a command is issued, the completed-burst tally is unchanged, so a further queued command whose burst already finished stays valid in the next cycle.
- R6: `s_awready` is low exactly while `CMD_DEPTH` commands are queued.
- R7: `s_wready` is low while `DATA_DEPTH` beats are queued.
- R8: `s_bvalid`, `s_bid` and `s_bresp` equal `m_bvalid`, `m_bid` and `m_bresp` in the same cycle, and `m_bready` equals `s_bready`.
- R9: A burst whose data, including WLAST, is fully accepted before its command arrives has its command offered on `m_aw*` in the cycle after that command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awid | input | ID_W | Incoming command id |
| s_awaddr | input | ADDR_W | Incoming command address |
| s_awlen | input | 8 | Incoming burst length minus one |
| s_awsize | input | 3 | Incoming beat size code |
| s_awburst | input | 2 | Incoming burst type |
| s_awvalid | input | 1 | Incoming command valid |
| s_awready | output | 1 | Command queue can accept |
| s_wdata | input | DATA_W | Incoming write data |
| s_wstrb | input | DATA_W/8 | Incoming byte strobes |
| s_wlast | input | 1 | Incoming last beat of burst |
| s_wvalid | input | 1 | Incoming beat valid |
| s_wready | output | 1 | Data queue can accept |
| s_bid | output | ID_W | Response id toward upstream |
| s_bresp | output | 2 | Response code toward upstream |
| s_bvalid | output | 1 | Response valid toward upstream |
| s_bready | input | 1 | Upstream takes response |
| m_awid | output | ID_W | Issued command id |
| m_awaddr | output | ADDR_W | Issued command address |
| m_awlen | output | 8 | Issued burst length minus one |
| m_awsize | output | 3 | Issued beat size code |
| m_awburst | output | 2 | Issued burst type |
| m_awvalid | output | 1 | Issued command valid |
| m_awready | input | 1 | Downstream takes command |
| m_wdata | output | DATA_W | Outgoing write data |
| m_wstrb | output | DATA_W/8 | Outgoing byte strobes |
| m_wlast | output | 1 | Outgoing last beat |
| m_wvalid | output | 1 | Outgoing beat valid |
| m_wready | input | 1 | Downstream takes beat |
| m_bid | input | ID_W | Response id from downstream |
| m_bresp | input | 2 | Response code from downstream |
| m_bvalid | input | 1 | Response valid from downstream |
| m_bready | output | 1 | Ready toward downstream response |

## Verification
The bench builds the block with `DATA_DEPTH`=8 and `CMD_DEPTH`=4 instead of the defaults of 512 and 32. At these depths the full-queue ready deassertion on both input channels is reached within a few dozen cycles, and the ordering, gating and same-cycle tally cases can be driven with stalled downstream handshakes without long fill phases. A behavioural queue model in the bench predicts every output on every clock.

// File: rtl/pkt_wr_pkg.sv
// Package pkt_wr_pkg
// Shared defaults and helpers for the write burst packet buffer.
// Assumes: depths are at least 2.
package pkt_wr_pkg;

    localparam int DEF_ID_W       = 4;
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_DATA_W     = 32;
    localparam int DEF_DATA_DEPTH = 512;
    localparam int DEF_CMD_DEPTH  = 32;
    localparam int LEN_W          = 8;
    localparam int SIZE_W         = 3;
    localparam int BURST_W        = 2;
    localparam int RESP_W         = 2;

    // Bits needed to hold the value n.
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pkt_sync_fifo.sv
// Module pkt_sync_fifo
// Single-clock first-in first-out queue with valid/ready on both sides.
// The head entry is read combinationally from the storage array, so an
// entry written in cycle t is visible at the output from cycle t+1.
// Assumes: DEPTH >= 2; push is refused while full even if a pop occurs.
module pkt_sync_fifo
    import pkt_wr_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [WIDTH-1:0] out_data
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int FILL_W = bits_for(DEPTH);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [FILL_W-1:0] FULL_FILL = FILL_W'(DEPTH);

    logic [WIDTH-1:0]  store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [FILL_W-1:0] fill;
    logic              push;
    logic              pop;

    // Wrap a pointer at the last slot so any depth works.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // Handshake decode and status flags.
    always_comb begin
        in_ready  = (fill != FULL_FILL);
        out_valid = (fill != '0);
        push      = in_valid && in_ready;
        pop       = out_valid && out_ready;
        out_data  = store[rd_ptr];
    end

    // Storage write; contents need no reset since fill guards reads.
    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= in_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/pkt_burst_tally.sv
// Module pkt_burst_tally
// Counts bursts whose data is complete but whose command is not yet issued.
// Goes up on a completed burst, down on an issued command, and holds when
// both happen in one cycle.
// Assumes: the caller never raises inc while at_max, nor dec while empty.
module pkt_burst_tally #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic has_burst,
    output logic at_max
);

    logic [CNT_W-1:0] tally;

    // Status decode for gating the command output and the data input.
    always_comb begin
        has_burst = (tally != '0);
        at_max    = (tally == '1);
    end

    // Up/down update with simultaneous events cancelling out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tally <= '0;
        end else if (inc && !dec) begin
            tally <= tally + 1'b1;
        end else if (dec && !inc) begin
            tally <= tally - 1'b1;
        end
    end

endmodule

// File: rtl/pkt_wr_buffer.sv
// Module pkt_wr_buffer (top)
// AXI4 write path buffer that releases each write command only after its
// whole data burst has been stored. Data beats flow out without waiting for
// their command; the response channel is a plain wire-through.
// Assumes: one clock, synchronous active-low reset, AXI4 full bursts only.
module pkt_wr_buffer
    import pkt_wr_pkg::*;
#(
    parameter int ID_W       = DEF_ID_W,
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int DATA_W     = DEF_DATA_W,
    parameter int DATA_DEPTH = DEF_DATA_DEPTH,
    parameter int CMD_DEPTH  = DEF_CMD_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ID_W-1:0]     s_awid,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic [LEN_W-1:0]    s_awlen,
    input  logic [SIZE_W-1:0]   s_awsize,
    input  logic [BURST_W-1:0]  s_awburst,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [DATA_W-1:0]   s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic                s_wlast,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [ID_W-1:0]     s_bid,
    output logic [RESP_W-1:0]   s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    output logic [ID_W-1:0]     m_awid,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [LEN_W-1:0]    m_awlen,
    output logic [SIZE_W-1:0]   m_awsize,
    output logic [BURST_W-1:0]  m_awburst,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [ID_W-1:0]     m_bid,
    input  logic [RESP_W-1:0]   m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready
);

    localparam int STRB_W  = DATA_W / 8;
    localparam int TALLY_W = bits_for(DATA_DEPTH) + 1;

    typedef struct packed {
        logic [ID_W-1:0]    id;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [SIZE_W-1:0]  size;
        logic [BURST_W-1:0] burst;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              last;
    } beat_t;

    localparam int CMD_BITS  = $bits(cmd_t);
    localparam int BEAT_BITS = $bits(beat_t);

    cmd_t  cmd_in, cmd_head;
    beat_t beat_in, beat_head;
    logic  cmd_present;
    logic  cmd_take;
    logic  data_room;
    logic  beat_push;
    logic  burst_done;
    logic  cmd_issue;
    logic  has_burst;
    logic  tally_full;

    // Pack the incoming channel fields into queue entries.
    always_comb begin
        cmd_in  = '{id: s_awid, addr: s_awaddr, len: s_awlen,
                    size: s_awsize, burst: s_awburst};
        beat_in = '{data: s_wdata, strb: s_wstrb, last: s_wlast};
    end

    // Command queue: shallow, popped only when a finished burst backs it.
    pkt_sync_fifo #(
        .WIDTH (CMD_BITS),
        .DEPTH (CMD_DEPTH)
    ) u_cmd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_awvalid),
        .in_ready  (s_awready),
        .in_data   (cmd_in),
        .out_valid (cmd_present),
        .out_ready (cmd_take),
        .out_data  (cmd_head)
    );

    // Data queue: deep, drains downstream with no packet gating.
    pkt_sync_fifo #(
        .WIDTH (BEAT_BITS),
        .DEPTH (DATA_DEPTH)
    ) u_data_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (beat_push),
        .in_ready  (data_room),
        .in_data   (beat_in),
        .out_valid (m_wvalid),
        .out_ready (m_wready),
        .out_data  (beat_head)
    );

    // Input data gating: stop a burst-closing beat if the tally is saturated.
    always_comb begin
        s_wready   = data_room && !(s_wlast && tally_full);
        beat_push  = s_wvalid && !(s_wlast && tally_full);
        burst_done = s_wvalid && s_wready && s_wlast;
    end

    // Completed-burst tally that licenses command release.
    pkt_burst_tally #(
        .CNT_W (TALLY_W)
    ) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (burst_done),
        .dec       (cmd_issue),
        .has_burst (has_burst),
        .at_max    (tally_full)
    );

    // Command release: head command goes out only with a finished burst.
    always_comb begin
        m_awvalid = cmd_present && has_burst;
        cmd_issue = m_awvalid && m_awready;
        cmd_take  = m_awready && has_burst;
        m_awid    = cmd_head.id;
        m_awaddr  = cmd_head.addr;
        m_awlen   = cmd_head.len;
        m_awsize  = cmd_head.size;
        m_awburst = cmd_head.burst;
    end

    // Outgoing beat fields from the data queue head.
    always_comb begin
        m_wdata = beat_head.data;
        m_wstrb = beat_head.strb;
        m_wlast = beat_head.last;
    end

    // Write response wire-through.
    always_comb begin
        s_bid    = m_bid;
        s_bresp  = m_bresp;
        s_bvalid = m_bvalid;
        m_bready = s_bready;
    end

endmodule

// File: rtl/pkt_wr_buffer_chk.sv
// Module pkt_wr_buffer_chk
// Port-level protocol checker for pkt_wr_buffer, attached with bind.
// It tracks queue occupancy and pending bursts from handshakes only.
// Assumes: the upstream manager respects AXI valid/ready rules.
module pkt_wr_buffer_chk #(
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int DATA_DEPTH = 512,
    parameter int CMD_DEPTH  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_awvalid,
    input logic              s_awready,
    input logic              s_wvalid,
    input logic              s_wready,
    input logic              s_wlast,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [ID_W-1:0]   m_awid,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              s_bvalid,
    input logic              m_bvalid,
    input logic              s_bready,
    input logic              m_bready,
    input logic [1:0]        s_bresp,
    input logic [1:0]        m_bresp
);

    int cmd_occ;
    int beat_occ;
    int pend;

    // Occupancy and pending-burst counts rebuilt from port handshakes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_occ  <= 0;
            beat_occ <= 0;
            pend     <= 0;
        end else begin
            cmd_occ  <= cmd_occ + int'(s_awvalid && s_awready)
                                - int'(m_awvalid && m_awready);
            beat_occ <= beat_occ + int'(s_wvalid && s_wready)
                                 - int'(m_wvalid && m_wready);
            pend     <= pend + int'(s_wvalid && s_wready && s_wlast)
                             - int'(m_awvalid && m_awready);
        end
    end

    // R1: outputs idle right after reset.
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!m_awvalid && !m_wvalid));

    // R4: a command is offered only with a finished burst behind it.
    a_r4_aw_needs_burst: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (pend > 0 && cmd_occ > 0));

    // R4: a finished burst plus a queued command means the command is offered.
    a_r4_aw_offered: assert property (@(posedge clk) disable iff (!rst_n)
        (pend > 0 && cmd_occ > 0) |-> m_awvalid);

    // R3: an offered command is held steady until taken.
    a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awid)));

    // R2: an offered beat is held steady until taken.
    a_r2_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    // R6: command input ready tracks queue space exactly.
    a_r6_aw_full: assert property (@(posedge clk) disable iff (!rst_n)
        s_awready == (cmd_occ < CMD_DEPTH));

    // R7: data input is refused when the data queue is full.
    a_r7_w_full: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_occ >= DATA_DEPTH) |-> !s_wready);

    // R8: response channel passes straight through.
    a_r8_b_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid == m_bvalid) && (m_bready == s_bready) && (s_bresp == m_bresp));

endmodule

bind pkt_wr_buffer pkt_wr_buffer_chk #(
    .ID_W       (ID_W),
    .DATA_W     (DATA_W),
    .DATA_DEPTH (DATA_DEPTH),
    .CMD_DEPTH  (CMD_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_wlast   (s_wlast),
    .m_awvalid (m_awvalid),
    .m_awready (m_awready),
    .m_awid    (m_awid),
    .m_wvalid  (m_wvalid),
    .m_wready  (m_wready),
    .m_wdata   (m_wdata),
    .s_bvalid  (s_bvalid),
    .m_bvalid  (m_bvalid),
    .s_bready  (s_bready),
    .m_bready  (m_bready),
    .s_bresp   (s_bresp),
    .m_bresp   (m_bresp)
);

// File: tb/pkt_wr_buffer_tb.sv
// Bench for pkt_wr_buffer: a queue-based reference model predicts every
// output each cycle; directed phases reach the corner cases.
module pkt_wr_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ID_W   = 4;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DDEPTH = 8;
    localparam int CDEPTH = 4;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ID_W-1:0]     s_awid = '0;
    logic [ADDR_W-1:0]   s_awaddr = '0;
    logic [7:0]          s_awlen = '0;
    logic [2:0]          s_awsize = 3'd2;
    logic [1:0]          s_awburst = 2'd1;
    logic                s_awvalid = 1'b0;
    logic                s_awready;
    logic [DATA_W-1:0]   s_wdata = '0;
    logic [DATA_W/8-1:0] s_wstrb = '1;
    logic                s_wlast = 1'b0;
    logic                s_wvalid = 1'b0;
    logic                s_wready;
    logic [ID_W-1:0]     s_bid;
    logic [1:0]          s_bresp;
    logic                s_bvalid;
    logic                s_bready = 1'b0;
    logic [ID_W-1:0]     m_awid;
    logic [ADDR_W-1:0]   m_awaddr;
    logic [7:0]          m_awlen;
    logic [2:0]          m_awsize;
    logic [1:0]          m_awburst;
    logic                m_awvalid;
    logic                m_awready = 1'b0;
    logic [DATA_W-1:0]   m_wdata;
    logic [DATA_W/8-1:0] m_wstrb;
    logic                m_wlast;
    logic                m_wvalid;
    logic                m_wready = 1'b0;
    logic [ID_W-1:0]     m_bid = '0;
    logic [1:0]          m_bresp = '0;
    logic                m_bvalid = 1'b0;
    logic                m_bready;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pkt_wr_buffer #(
        .ID_W (ID_W), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
        .DATA_DEPTH (DDEPTH), .CMD_DEPTH (CDEPTH)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .s_awid (s_awid), .s_awaddr (s_awaddr), .s_awlen (s_awlen),
        .s_awsize (s_awsize), .s_awburst (s_awburst),
        .s_awvalid (s_awvalid), .s_awready (s_awready),
        .s_wdata (s_wdata), .s_wstrb (s_wstrb), .s_wlast (s_wlast),
        .s_wvalid (s_wvalid), .s_wready (s_wready),
        .s_bid (s_bid), .s_bresp (s_bresp), .s_bvalid (s_bvalid),
        .s_bready (s_bready),
        .m_awid (m_awid), .m_awaddr (m_awaddr), .m_awlen (m_awlen),
        .m_awsize (m_awsize), .m_awburst (m_awburst),
        .m_awvalid (m_awvalid), .m_awready (m_awready),
        .m_wdata (m_wdata), .m_wstrb (m_wstrb), .m_wlast (m_wlast),
        .m_wvalid (m_wvalid), .m_wready (m_wready),
        .m_bid (m_bid), .m_bresp (m_bresp), .m_bvalid (m_bvalid),
        .m_bready (m_bready)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    // Reference model state.
    logic [ID_W+ADDR_W+8-1:0] cmd_q[$];
    logic [DATA_W:0]          beat_q[$];
    int                       done_cnt = 0;

    task automatic check(input bit ok, input string tag, input longint act,
                         input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, then model advance.
    always @(negedge clk) begin
        bit e_awv, e_awr, e_wv, e_wr;
        cycles++;
        if (!rst_n) begin
            cmd_q.delete();
            beat_q.delete();
            done_cnt = 0;
        end else begin
            e_awv = (cmd_q.size() > 0) && (done_cnt > 0);
            e_awr = cmd_q.size() < CDEPTH;
            e_wv  = beat_q.size() > 0;
            e_wr  = beat_q.size() < DDEPTH;
            check(m_awvalid == e_awv, "R4 m_awvalid", m_awvalid, e_awv);
            check(s_awready == e_awr, "R6 s_awready", s_awready, e_awr);
            check(m_wvalid == e_wv, "R2 m_wvalid", m_wvalid, e_wv);
            check(s_wready == e_wr, "R7 s_wready", s_wready, e_wr);
            if (e_awv) begin
                check({m_awid, m_awaddr, m_awlen} == cmd_q[0], "R3 m_aw fields",
                      {m_awid, m_awaddr, m_awlen}, cmd_q[0]);
            end
            if (e_wv) begin
                check({m_wlast, m_wdata} == beat_q[0], "R2 m_w fields",
                      {m_wlast, m_wdata}, beat_q[0]);
            end
            if (e_awv && m_awready) begin
                void'(cmd_q.pop_front());
                done_cnt--;
            end
            if (e_wv && m_wready) void'(beat_q.pop_front());
            if (s_awvalid && e_awr) cmd_q.push_back({s_awid, s_awaddr, s_awlen});
            if (s_wvalid && e_wr) begin
                beat_q.push_back({s_wlast, s_wdata});
                if (s_wlast) done_cnt++;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_aw(input int id, input int addr, input int len);
        bit ok;
        s_awid = ID_W'(id);
        s_awaddr = ADDR_W'(addr);
        s_awlen = 8'(len);
        s_awvalid = 1'b1;
        do begin
            @(negedge clk);
            ok = s_awready;
            tick();
        end while (!ok);
        s_awvalid = 1'b0;
    endtask

    task automatic send_burst(input int base, input int beats);
        for (int i = 0; i < beats; i++) begin
            bit ok;
            s_wdata = DATA_W'(base + i);
            s_wlast = (i == beats - 1);
            s_wvalid = 1'b1;
            do begin
                @(negedge clk);
                ok = s_wready;
                tick();
            end while (!ok);
        end
        s_wvalid = 1'b0;
        s_wlast = 1'b0;
    endtask

    task automatic drain();
        m_awready = 1'b1;
        m_wready = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (cmd_q.size() == 0 && beat_q.size() == 0) break;
            tick();
        end
        check(cmd_q.size() == 0 && beat_q.size() == 0, "R3 drained",
              cmd_q.size() + beat_q.size(), 0);
    endtask

    task automatic run();
        // R1: state during and right after reset.
        repeat (3) tick();
        @(negedge clk);
        check(!m_awvalid && !m_wvalid, "R1 valids in reset", {m_awvalid, m_wvalid}, 0);
        tick();
        rst_n = 1'b1;
        @(negedge clk);
        check(!m_awvalid && !m_wvalid && s_awready && s_wready, "R1 after reset",
              {m_awvalid, m_wvalid, s_awready, s_wready}, 4'b0011);
        tick();

        // R4: command first, then burst; command appears only after WLAST.
        m_wready = 1'b1;
        m_awready = 1'b1;
        send_aw(1, 32'h1000, 3);
        @(negedge clk);
        check(!m_awvalid, "R4 held before data", m_awvalid, 0);
        tick();
        send_burst(32'hA0, 4);
        @(negedge clk);
        check(m_awvalid && m_awid == 1, "R4 released after WLAST", m_awvalid, 1);
        tick();
        drain();

        // R9 and R2: data first (beats leave before any command), then command.
        m_awready = 1'b1;
        send_burst(32'hB0, 2);
        @(negedge clk);
        check(!m_awvalid, "R2 data ahead of command", m_awvalid, 0);
        tick();
        send_aw(2, 32'h2000, 1);
        @(negedge clk);
        check(m_awvalid && m_awid == 2, "R9 command after stored burst", m_awid, 2);
        tick();
        drain();

        // R6: fill the command queue with downstream stalled.
        m_awready = 1'b0;
        m_wready = 1'b0;
        for (int i = 0; i < CDEPTH; i++) send_aw(4 + i, 32'h4000 + i * 16, 3);
        @(negedge clk);
        check(!s_awready, "R6 command queue full", s_awready, 0);
        tick();
        // R7: fill the data queue.
        send_burst(32'hC0, 4);
        send_burst(32'hC4, 4);
        @(negedge clk);
        check(!s_wready, "R7 data queue full", s_wready, 0);
        tick();
        fork
            drain();
            begin
                send_burst(32'hC8, 4);
                send_burst(32'hCC, 4);
            end
        join
        drain();

        // R5: WLAST accepted in the same cycle a command issues.
        m_awready = 1'b0;
        m_wready = 1'b1;
        send_aw(9, 32'h9000, 0);
        send_burst(32'hD0, 1);
        send_aw(10, 32'hA000, 0);
        s_wdata = 32'hD1;
        s_wlast = 1'b1;
        s_wvalid = 1'b1;
        m_awready = 1'b1;
        @(negedge clk);
        check(m_awvalid && s_wready && m_awid == 9, "R5 overlap cycle", m_awid, 9);
        tick();
        s_wvalid = 1'b0;
        s_wlast = 1'b0;
        @(negedge clk);
        check(m_awvalid && m_awid == 10, "R5 tally kept", m_awvalid, 1);
        tick();
        drain();

        // R8: response wire-through under several patterns.
        for (int i = 0; i < 6; i++) begin
            m_bvalid = i[0];
            m_bid = ID_W'(i * 3);
            m_bresp = 2'(i);
            s_bready = i[1];
            @(negedge clk);
            check(s_bvalid == m_bvalid && s_bid == m_bid && s_bresp == m_bresp
                  && m_bready == s_bready, "R8 response path",
                  {s_bvalid, s_bid, s_bresp, m_bready},
                  {m_bvalid, m_bid, m_bresp, s_bready});
            tick();
        end
        m_bvalid = 1'b0;
    endtask

    initial begin
        fork
            run();
            begin
                wait (cycles > WATCHDOG);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule